// File: doc/BRIEF.md
# Per-CPU Interrupt Acknowledge and Completion Interface

This block is the register interface that one processor uses to take and retire interrupts. The processor enables its interface, sets a priority ceiling and then reads an acknowledge register. That read returns the interrupt ID offered by the priority selector and makes that ID the running one. When the handler is done, software writes the ID to an end-of-interrupt register, and the block restores whichever interrupt was running before.

Each interrupt ID has its own predecessor link and saved priority, so nested interrupts form a chain. The chain is stored in a table indexed by ID, not in a stack. Completing the running ID restores its predecessor in one cycle. Completing an ID that sits deeper in the chain starts a walk from the running ID, one link per clock, which splices the ID out of the chain. While the walk runs, `walk_busy` is high and bus accesses are not accepted.

The block does not store pending state. It reads the pending ID, its priority and its sharing model from the selector and returns a pending-clear command. For each completion it asks the selector for the completed ID's trigger, enable, level and target state, and may return a re-pend command.

Top module: `irq_cpu_iface`

## Requirements
- R1: After reset, control (offset 0x00) reads 0, priority mask (0x04) reads 0xF0, running priority (0x14) reads 0x100, the highest-pending read (0x18) returns 1023, and `walk_busy` is low.
- R2: Bit 0 of a write to 0x00 sets the interface enable. The low 8 bits of a write to 0x04 set the mask. Both read back. Unused offsets such as 0x08 and 0x1C read as zero.
- R3: The highest-pending read returns `pend_id` only when the interface is enabled, `pend_id` is not 1023 and `pend_prio` is less than or equal to the mask. Otherwise it returns 1023.
- R4: An acknowledge read (0x0C) returns 1023 and changes nothing when the highest-pending value is 1023 or `pend_prio` is not strictly below the running priority. In that case `clr_valid` stays low.
- R5: A successful acknowledge does the following in the cycle of the read:
  - it returns the ID;
  - it pulses `clr_valid` with `clr_id` set to the ID and `clr_all` equal to `pend_model` (1 = clear for every CPU);
  - it saves the previous running ID and running priority as the ID's predecessor.
  From the next cycle, that ID is running at `pend_prio`.
- R6: An end-of-interrupt write (0x10, ID in bits 9:0) is ignored while the running ID is 1023: no re-pend, no state change and no walk.
- R7: An accepted end-of-interrupt pulses `repend_valid` with `repend_id` equal to the written ID exactly when `q_edge` is 0 and `q_enabled`, `q_level` and `q_targeted` are all 1. `q_id` carries the written ID.
- R8: Completing the running ID makes its predecessor the running ID and restores the running priority saved at its acknowledge. The running priority reads 0x100 when the chain becomes empty.
- R9: Completing a non-running ID leaves the running ID and priority unchanged. It holds `walk_busy` high for k cycles, where k is the number of links followed from the running ID to reach the ID, or the chain length if the ID is absent. A found ID is removed, and the rest of the chain stays in order.
- R10: While `walk_busy` is high, register writes have no effect, and an acknowledge read returns 1023 and does not pulse `clr_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (acknowledge side effect at 0x0C) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| walk_busy | output | 1 | Chain walk in progress; accesses not accepted |
| pend_id | input | 10 | Best pending ID from selector, 1023 for none |
| pend_prio | input | 8 | Priority of `pend_id` |
| pend_model | input | 1 | `pend_id` uses the 1-of-N model |
| clr_valid | output | 1 | Pending-clear command |
| clr_id | output | 10 | ID to clear |
| clr_all | output | 1 | Clear for all CPUs (else this CPU only) |
| q_id | output | 10 | ID whose state is queried at completion |
| q_edge | input | 1 | Queried ID is edge-triggered |
| q_enabled | input | 1 | Queried ID is enabled |
| q_level | input | 1 | Queried ID's input is high |
| q_targeted | input | 1 | Queried ID targets this CPU |
| repend_valid | output | 1 | Re-pend command |
| repend_id | output | 10 | ID to mark pending again |

## Verification
An out-of-order completion's chain walk and a new acknowledge read can fall in the same cycle. To provoke this, the bench issues the acknowledge read, with a winning pending ID, in the clock that follows a completion that needs a two-link walk. It also issues a control write in the middle of a walk of a completion ID that is not in the chain. The collision is judged as correct when the read returns 1023 with no clear pulse and the control value is unchanged afterwards. The same acknowledge must then succeed once `walk_busy` falls, with a walk length that matches the reference chain.

// File: rtl/irq_cpu_iface.sv
`timescale 1ns/1ps
module irq_cpu_iface #(
  parameter int NUM_IDS = 64,
  parameter int ID_W    = 10,
  parameter int PRIO_W  = 8,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              walk_busy,
  input  logic [ID_W-1:0]   pend_id,
  input  logic [PRIO_W-1:0] pend_prio,
  input  logic              pend_model,
  output logic              clr_valid,
  output logic [ID_W-1:0]   clr_id,
  output logic              clr_all,
  output logic [ID_W-1:0]   q_id,
  input  logic              q_edge,
  input  logic              q_enabled,
  input  logic              q_level,
  input  logic              q_targeted,
  output logic              repend_valid,
  output logic [ID_W-1:0]   repend_id
);
  localparam int IDX_W = $clog2(NUM_IDS);
  localparam int RP_W  = PRIO_W + 1;
  localparam logic [ID_W-1:0] NONE    = '1;
  localparam logic [RP_W-1:0] IDLE_RP = RP_W'(1) << PRIO_W;
  localparam logic [ADDR_W-1:0] OFF_CTRL  = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] OFF_PMASK = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] OFF_ACK   = ADDR_W'(8'h0C);
  localparam logic [ADDR_W-1:0] OFF_EOI   = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] OFF_RUNP  = ADDR_W'(8'h14);
  localparam logic [ADDR_W-1:0] OFF_HP    = ADDR_W'(8'h18);

  logic              cpu_en;
  logic [PRIO_W-1:0] pmask;
  logic [ID_W-1:0]   run_id, walk_cur, walk_tgt;
  logic [RP_W-1:0]   run_prio;
  logic [ID_W-1:0]   link  [NUM_IDS];
  logic [RP_W-1:0]   lprio [NUM_IDS];

  logic [ID_W-1:0] hp_id, eoi_id, walk_nxt;
  logic rd_ok, wr_ok, ack_ok, ack_fire, eoi_fire;
  logic unused_wdata;

  assign unused_wdata = ^bus_wdata[DATA_W-1:ID_W];
  assign rd_ok    = bus_rd & ~walk_busy;
  assign wr_ok    = bus_wr & ~walk_busy;
  assign hp_id    = (cpu_en && pend_id != NONE && pend_prio <= pmask) ? pend_id : NONE;
  assign ack_ok   = (hp_id != NONE) && ({1'b0, pend_prio} < run_prio);
  assign ack_fire = rd_ok && bus_addr == OFF_ACK && ack_ok;
  assign eoi_id   = bus_wdata[ID_W-1:0];
  assign eoi_fire = wr_ok && bus_addr == OFF_EOI && run_id != NONE;
  assign walk_nxt = link[walk_cur[IDX_W-1:0]];

  assign clr_valid    = ack_fire;
  assign clr_id       = hp_id;
  assign clr_all      = pend_model;
  assign q_id         = eoi_id;
  assign repend_id    = eoi_id;
  assign repend_valid = eoi_fire & ~q_edge & q_enabled & q_level & q_targeted;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFF_CTRL:  bus_rdata[0]          = cpu_en;
      OFF_PMASK: bus_rdata[PRIO_W-1:0] = pmask;
      OFF_ACK:   bus_rdata[ID_W-1:0]   = ack_fire ? hp_id : NONE;
      OFF_RUNP:  bus_rdata[RP_W-1:0]   = run_prio;
      OFF_HP:    bus_rdata[ID_W-1:0]   = hp_id;
      default:   bus_rdata             = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_en    <= 1'b0;
      pmask     <= PRIO_W'(8'hF0);
      run_id    <= NONE;
      run_prio  <= IDLE_RP;
      walk_busy <= 1'b0;
      walk_cur  <= NONE;
      walk_tgt  <= NONE;
      for (int i = 0; i < NUM_IDS; i++) begin
        link[i]  <= NONE;
        lprio[i] <= IDLE_RP;
      end
    end else begin
      if (wr_ok && bus_addr == OFF_CTRL)  cpu_en <= bus_wdata[0];
      if (wr_ok && bus_addr == OFF_PMASK) pmask  <= bus_wdata[PRIO_W-1:0];
      if (ack_fire) begin
        link[hp_id[IDX_W-1:0]]  <= run_id;
        lprio[hp_id[IDX_W-1:0]] <= run_prio;
        run_id   <= hp_id;
        run_prio <= {1'b0, pend_prio};
      end
      if (eoi_fire) begin
        if (eoi_id == run_id) begin
          run_id   <= link[run_id[IDX_W-1:0]];
          run_prio <= lprio[run_id[IDX_W-1:0]];
        end else begin
          walk_busy <= 1'b1;
          walk_cur  <= run_id;
          walk_tgt  <= eoi_id;
        end
      end
      if (walk_busy) begin
        if (walk_nxt == NONE) begin
          walk_busy <= 1'b0;
        end else if (walk_nxt == walk_tgt) begin
          link[walk_cur[IDX_W-1:0]]  <= link[walk_tgt[IDX_W-1:0]];
          lprio[walk_cur[IDX_W-1:0]] <= lprio[walk_tgt[IDX_W-1:0]];
          walk_busy <= 1'b0;
        end else begin
          walk_cur <= walk_nxt;
        end
      end
    end
  end

  // R8
  idle_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_id == NONE |-> run_prio == IDLE_RP);
  // R5
  ack_takes_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_valid |=> run_id == $past(clr_id));
  // R5
  ack_raises_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_valid |=> run_prio < $past(run_prio));
  // R10
  no_ack_in_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    walk_busy |-> !clr_valid && !repend_valid);
  // R9
  walk_keeps_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    walk_busy |=> $stable(run_id) && $stable(run_prio));
  // R6
  idle_eoi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFF_EOI && run_id == NONE && !walk_busy)
      |=> run_id == NONE && !walk_busy);
endmodule

// File: tb/irq_cpu_iface_tb.sv
`timescale 1ns/1ps
module irq_cpu_iface_tb;
  localparam int N = 64;
  localparam int NONE = 1023;

  logic clk = 0, rst_n = 0;
  logic [7:0] bus_addr = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic walk_busy;
  logic [9:0] pend_id = 10'(NONE);
  logic [7:0] pend_prio = 0;
  logic pend_model = 0;
  logic clr_valid, clr_all, repend_valid;
  logic [9:0] clr_id, q_id, repend_id;
  logic q_edge = 0, q_enabled = 0, q_level = 0, q_targeted = 0;

  irq_cpu_iface u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .walk_busy(walk_busy),
    .pend_id(pend_id), .pend_prio(pend_prio), .pend_model(pend_model),
    .clr_valid(clr_valid), .clr_id(clr_id), .clr_all(clr_all), .q_id(q_id),
    .q_edge(q_edge), .q_enabled(q_enabled), .q_level(q_level), .q_targeted(q_targeted),
    .repend_valid(repend_valid), .repend_id(repend_id));

  always #5 clk = ~clk;

  int ncmp = 0, nbad = 0, cycles = 0;
  int mlink [N];
  int mlp [N];
  int mrun = NONE, mrp = 256, men = 0, mmask = 8'hF0;
  int left_cyc = 0;

  task automatic chk(string req, int act, int exp);
    ncmp++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nbad++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
      $finish;
    end
  end

  function automatic int exp_hp(int id, int pr);
    return (men != 0 && id != NONE && pr <= mmask) ? id : NONE;
  endfunction

  function automatic bit in_chain(int id);
    int t = mrun;
    while (t != NONE) begin
      if (t == id) return 1;
      t = mlink[t];
    end
    return 0;
  endfunction

  task automatic rd_reg(input logic [7:0] a, output int d);
    @(negedge clk); bus_rd = 1; bus_addr = a; #1;
    d = int'(bus_rdata);
    @(posedge clk); #1 bus_rd = 0;
  endtask

  task automatic wr_reg(input logic [7:0] a, input int d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1 bus_wr = 0;
  endtask

  task automatic do_ack(input int id, input int pr, input bit mdl, input string tag);
    bit ok;
    @(negedge clk);
    pend_id = 10'(id); pend_prio = 8'(pr); pend_model = mdl;
    bus_rd = 1; bus_addr = 8'h0C; #1;
    ok = exp_hp(id, pr) != NONE && pr < mrp;
    chk(tag, int'(bus_rdata), ok ? id : NONE);
    chk(tag, int'(clr_valid), int'(ok));
    if (ok) begin
      chk(tag, int'(clr_id), id);
      chk(tag, int'(clr_all), int'(mdl));
    end
    @(posedge clk); #1 bus_rd = 0;
    if (ok) begin
      mlink[id] = mrun; mlp[id] = mrp; mrun = id; mrp = pr;
    end
  endtask

  task automatic do_eoi(input int id, input bit qe, input bit qen, input bit ql,
                        input bit qt, input bit wait_done, input string tag);
    bit rep;
    int t, n, d;
    @(negedge clk);
    q_edge = qe; q_enabled = qen; q_level = ql; q_targeted = qt;
    bus_wr = 1; bus_addr = 8'h10; bus_wdata = id; #1;
    rep = mrun != NONE && !qe && qen && ql && qt;
    chk({tag, " repend"}, int'(repend_valid), int'(rep));
    chk({tag, " q_id"}, int'(q_id), id);
    if (rep) chk({tag, " repend_id"}, int'(repend_id), id);
    @(posedge clk); #1 bus_wr = 0;
    left_cyc = 0;
    if (mrun != NONE) begin
      if (id == mrun) begin
        mrun = mlink[id]; mrp = mlp[id];
      end else begin
        t = mrun;
        forever begin
          left_cyc++;
          n = mlink[t];
          if (n == NONE) break;
          if (n == id) begin mlink[t] = mlink[id]; mlp[t] = mlp[id]; break; end
          t = n;
        end
      end
    end
    if (wait_done) begin
      wait_walk({tag, " walk cycles"});
      rd_reg(8'h14, d);
      chk({tag, " run prio"}, d, mrp);
    end
  endtask

  task automatic wait_walk(input string tag);
    int c = 0;
    while (walk_busy) begin
      @(posedge clk); #1;
      c++;
    end
    chk(tag, c, left_cyc);
  endtask

  initial begin
    int d;
    for (int i = 0; i < N; i++) begin mlink[i] = NONE; mlp[i] = 256; end
    #23 rst_n = 1;
    #1;
    chk("R1 busy", int'(walk_busy), 0);
    rd_reg(8'h00, d); chk("R1 ctrl", d, 0);
    rd_reg(8'h04, d); chk("R1 mask", d, 8'hF0);
    rd_reg(8'h14, d); chk("R1 runprio", d, 256);
    pend_id = 5; pend_prio = 8'h10;
    rd_reg(8'h18, d); chk("R1 hp", d, NONE);
    rd_reg(8'h08, d); chk("R2 unused 08", d, 0);
    rd_reg(8'h1C, d); chk("R2 unused 1C", d, 0);

    wr_reg(8'h00, 32'hFFFF_FFFF); men = 1;
    rd_reg(8'h00, d); chk("R2 ctrl", d, 1);
    wr_reg(8'h04, 32'h3A5);
    rd_reg(8'h04, d); chk("R2 mask low bits", d, 8'hA5);
    wr_reg(8'h04, 32'hF0);

    pend_id = 5; pend_prio = 8'hF0;
    rd_reg(8'h18, d); chk("R3 prio equal mask", d, 5);
    pend_prio = 8'hF1;
    rd_reg(8'h18, d); chk("R3 prio above mask", d, NONE);
    pend_id = 10'(NONE); pend_prio = 0;
    rd_reg(8'h18, d); chk("R3 none pending", d, NONE);

    do_ack(5, 8'h80, 1, "R5 ack first");
    rd_reg(8'h14, d); chk("R5 runprio", d, 8'h80);
    do_ack(9, 8'h80, 0, "R4 equal prio refused");
    rd_reg(8'h14, d); chk("R4 runprio kept", d, 8'h80);
    do_ack(9, 8'h40, 0, "R5 nested ack");
    do_ack(12, 8'h20, 1, "R5 third ack");
    do_eoi(12, 0, 1, 1, 1, 1, "R8 complete running");
    chk("R8 runprio restored", mrp, 8'h40);
    do_ack(20, 8'h10, 0, "R5 ack 20");

    // R10: acknowledge collides with a walk
    do_eoi(5, 0, 0, 0, 0, 0, "R9 complete bottom");
    @(negedge clk);
    pend_id = 30; pend_prio = 8'h08; pend_model = 0;
    bus_rd = 1; bus_addr = 8'h0C; #1;
    chk("R10 ack during walk data", int'(bus_rdata), NONE);
    chk("R10 ack during walk clr", int'(clr_valid), 0);
    @(posedge clk); #1 bus_rd = 0;
    left_cyc = left_cyc - 1;
    wait_walk("R9 walk cycles");
    rd_reg(8'h14, d); chk("R9 runprio unchanged", d, 8'h10);
    do_ack(30, 8'h08, 0, "R10 ack after walk");
    do_eoi(9, 0, 1, 0, 1, 1, "R9 unlink middle");
    do_eoi(20, 0, 1, 1, 0, 1, "R9 unlink top-1");
    do_eoi(30, 0, 1, 1, 1, 1, "R8 complete last");
    rd_reg(8'h14, d); chk("R8 empty chain prio", d, 256);

    do_eoi(7, 0, 1, 1, 1, 1, "R6 idle completion");
    chk("R6 run empty", int'(walk_busy), 0);

    do_ack(7, 8'h50, 0, "R5 ack 7");
    do_ack(8, 8'h30, 0, "R5 ack 8");
    do_eoi(40, 0, 1, 1, 1, 0, "R7 absent id repend");
    wr_reg(8'h00, 0);
    left_cyc = left_cyc - 1;
    wait_walk("R9 absent walk cycles");
    rd_reg(8'h00, d); chk("R10 write during walk ignored", d, 1);
    do_eoi(8, 1, 1, 1, 1, 1, "R7 edge no repend");
    do_eoi(7, 0, 1, 1, 0, 1, "R7 untargeted no repend");

    // random phase
    wr_reg(8'h04, 8'hFF); mmask = 8'hFF;
    void'($urandom(32'd1234));
    for (int it = 0; it < 600; it++) begin
      int op = $urandom_range(0, 9);
      if (op < 4 || mrun == NONE) begin
        int id;
        do id = $urandom_range(0, N - 1); while (in_chain(id));
        do_ack(id, $urandom_range(0, 255), 1'($urandom_range(0, 1)), "R5 random ack");
      end else if (op < 8) begin
        int id, t, steps;
        if ($urandom_range(0, 3) != 0) begin
          t = mrun; steps = $urandom_range(0, 6);
          for (int s = 0; s < steps; s++) if (mlink[t] != NONE) t = mlink[t];
          id = t;
        end else id = $urandom_range(0, N - 1);
        do_eoi(id, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
               1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1, "R9 random completion");
      end else begin
        int id = $urandom_range(0, N - 1), pr = $urandom_range(0, 255);
        pend_id = 10'(id); pend_prio = 8'(pr);
        rd_reg(8'h18, d); chk("R3 random hp", d, exp_hp(id, pr));
      end
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
    $finish;
  end
endmodule